// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block connects a clocked host to an external 128K x 8 asynchronous static RAM. The host raises a one-cycle request with a read/write flag, an address and, for writes, a data byte. The controller then drives the memory's address lines, its two select lines of opposite polarity, its read enable and its write enable. It spaces each phase by counting clock cycles, and it returns read data with a one-cycle completion pulse.

All memory timing is given as nanosecond values that a speed-grade parameter picks. Two grades are supported, 70 and 100. A clock-period parameter turns each value into a cycle count: the ceiling of the time divided by the period, and never less than one. The data bus is split into an output value, an output enable and an input sample, so the pad ring can build the tri-state buffer. After a read, the controller keeps itself busy for a turnaround gap, so that the memory's late output release cannot collide with the next write.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, and whenever `busy_o` is low, the memory is held deselected: `mem_sel_n_o`=1, `mem_sel_o`=0, `mem_rd_n_o`=1, `mem_wr_n_o`=1, `mem_d_oe_o`=0.
- R2: A read request taken while idle selects the memory (`mem_sel_n_o`=0, `mem_sel_o`=1) with `mem_rd_n_o`=0 and `mem_wr_n_o`=1. This holds for exactly RD = ceil(max(cycle time, access time, read-enable access)/period) cycles, which is 7 at grade 70 and period 10. The requested address stays steady on `mem_a_o` during this window.
- R3: `mem_d_i` is sampled on the last cycle of the read window. The sampled byte appears on `rdata_o` in the next cycle, while `done_o` is high for exactly one cycle.
- R4: After a read, select and read enable are removed together. `busy_o` then stays high for HZ = ceil(release time/period) more cycles (3 at grade 70), so the controller never drives the bus while the memory may still drive it.
- R5: A write request taken while idle selects the memory with `mem_wr_n_o`=0 and `mem_rd_n_o`=1. This holds for WE = max(ceil(max(pulse, select-to-end, address-to-end, data setup)/period), ceil(write cycle/period)-1) cycles, which is 6 at grade 70 and period 10.
- R6: `mem_d_oe_o` is high only while `mem_wr_n_o` is low and the memory is selected. While it is high, `mem_d_o` carries the request's write byte.
- R7: For one cycle after `mem_wr_n_o` rises, the memory stays selected, `mem_d_oe_o` is low, and `mem_a_o` and `mem_d_o` keep their write values. In the following cycle `done_o` pulses and the pins return to the R1 state.
- R8: A request raised while `busy_o` is high is ignored. The access in progress keeps its address and timing, no further access starts afterwards, and a write raised while busy leaves the memory unchanged.
- R9: `busy_o` is high for RD+HZ cycles after a read is accepted and for WE+1 cycles after a write is accepted. A new request is accepted in the first cycle that `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_i | input | 1 | Access request, sampled when idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 17 | Byte address |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Read byte, valid with `done_o` after a read |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Access or turnaround in progress |
| mem_a_o | output | 17 | Memory address lines |
| mem_d_o | output | 8 | Data bus output value |
| mem_d_oe_o | output | 1 | Data bus output enable |
| mem_d_i | input | 8 | Data bus input sample |
| mem_sel_n_o | output | 1 | Active-low memory select |
| mem_sel_o | output | 1 | Active-high memory select |
| mem_rd_n_o | output | 1 | Active-low output enable of the memory |
| mem_wr_n_o | output | 1 | Active-low write enable |

## Verification
The memory model in the bench returns the inverse of the stored byte until the access time has run out. It keeps driving the bus for the release time after a read ends. A design that samples one cycle early therefore returns wrong data, and a design whose turnaround is short trips the bus-contention monitor or the busy-length check. Every write is checked cycle by cycle for write-enable length, data-drive window and the post-write hold cycle, so a missing hold or a drive enable that outlives the write pulse shows up at once. Requests raised in mid-access must leave the pins untouched and must leave a never-written location reading zero; a design that queues or accepts them fails both checks.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_HOLD,
        ST_TURN
    } ctrl_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // ceiling of ns / clk_ns, never below one cycle
    function automatic int ns2cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/sram_pin_regs.sv
module sram_pin_regs #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_d,
    input  logic              rd_d,
    input  logic              wr_d,
    input  logic [ADDR_W-1:0] a_d,
    input  logic [DATA_W-1:0] dat_d,
    output logic              sel_n_o,
    output logic              sel_o,
    output logic              rd_n_o,
    output logic              wr_n_o,
    output logic              d_oe_o,
    output logic [ADDR_W-1:0] a_o,
    output logic [DATA_W-1:0] d_o
);
    typedef struct packed {
        logic              sel_n;
        logic              sel;
        logic              rd_n;
        logic              wr_n;
        logic              d_oe;
        logic [ADDR_W-1:0] a;
        logic [DATA_W-1:0] dat;
    } pins_t;

    pins_t p_d, p_q;

    always_comb begin
        p_d.sel_n = ~sel_d;
        p_d.sel   = sel_d;
        p_d.rd_n  = ~rd_d;
        p_d.wr_n  = ~wr_d;
        p_d.d_oe  = wr_d;
        p_d.a     = a_d;
        p_d.dat   = dat_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q.sel_n <= 1'b1;
            p_q.sel   <= 1'b0;
            p_q.rd_n  <= 1'b1;
            p_q.wr_n  <= 1'b1;
            p_q.d_oe  <= 1'b0;
            p_q.a     <= '0;
            p_q.dat   <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign sel_n_o = p_q.sel_n;
    assign sel_o   = p_q.sel;
    assign rd_n_o  = p_q.rd_n;
    assign wr_n_o  = p_q.wr_n;
    assign d_oe_o  = p_q.d_oe;
    assign a_o     = p_q.a;
    assign d_o     = p_q.dat;
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int DATA_W   = 8,
    parameter int CLK_NS   = 10,
    parameter int SPEED_NS = 70
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              done_o,
    output logic              busy_o,
    output logic [ADDR_W-1:0] mem_a_o,
    output logic [DATA_W-1:0] mem_d_o,
    output logic              mem_d_oe_o,
    input  logic [DATA_W-1:0] mem_d_i,
    output logic              mem_sel_n_o,
    output logic              mem_sel_o,
    output logic              mem_rd_n_o,
    output logic              mem_wr_n_o
);
    // per-grade timing in ns
    localparam bit SLOW   = (SPEED_NS >= 100);
    localparam int T_CYC  = SLOW ? 100 : 70;
    localparam int T_ACC  = SLOW ? 100 : 70;
    localparam int T_OEA  = SLOW ? 50  : 35;
    localparam int T_WCYC = SLOW ? 100 : 70;
    localparam int T_WPL  = SLOW ? 70  : 55;
    localparam int T_SEL  = SLOW ? 80  : 60;
    localparam int T_ADR  = SLOW ? 80  : 60;
    localparam int T_DSU  = SLOW ? 40  : 30;
    localparam int T_REL  = SLOW ? 30  : 25;

    localparam int RD_CYC = ns2cyc(imax(T_CYC, imax(T_ACC, T_OEA)), CLK_NS);
    localparam int WE_CYC = imax(ns2cyc(imax(imax(T_WPL, T_SEL), imax(T_ADR, T_DSU)), CLK_NS),
                                 ns2cyc(T_WCYC, CLK_NS) - 1);
    localparam int HZ_CYC = ns2cyc(T_REL, CLK_NS);
    localparam int MAX_CYC = imax(RD_CYC, imax(WE_CYC, HZ_CYC));
    localparam int CNT_W  = $clog2(MAX_CYC + 1);

    typedef struct packed {
        ctrl_state_e       st;
        logic [ADDR_W-1:0] a;
        logic [DATA_W-1:0] wd;
        logic [DATA_W-1:0] rd;
        logic              done;
    } ctrl_t;

    ctrl_t            r_d, r_q;
    logic             ld;
    logic [CNT_W-1:0] ld_val;
    logic             last;
    logic             sel_d, rd_d, wr_d;

    always_comb begin
        r_d     = r_q;
        r_d.done = 1'b0;
        ld      = 1'b0;
        ld_val  = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_i) begin
                    r_d.a  = addr_i;
                    r_d.wd = wdata_i;
                    ld     = 1'b1;
                    if (we_i) begin
                        r_d.st = ST_WRITE;
                        ld_val = CNT_W'(WE_CYC);
                    end else begin
                        r_d.st = ST_READ;
                        ld_val = CNT_W'(RD_CYC);
                    end
                end
            end
            ST_READ: begin
                if (last) begin
                    r_d.rd   = mem_d_i;
                    r_d.done = 1'b1;
                    r_d.st   = ST_TURN;
                    ld       = 1'b1;
                    ld_val   = CNT_W'(HZ_CYC);
                end
            end
            ST_WRITE: begin
                if (last) begin
                    r_d.st = ST_HOLD;
                end
            end
            ST_HOLD: begin
                r_d.st   = ST_IDLE;
                r_d.done = 1'b1;
            end
            ST_TURN: begin
                if (last) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st   <= ST_IDLE;
            r_q.a    <= '0;
            r_q.wd   <= '0;
            r_q.rd   <= '0;
            r_q.done <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    // pin decode from the next state, registered in the pin stage
    assign sel_d = (r_d.st == ST_READ) || (r_d.st == ST_WRITE) || (r_d.st == ST_HOLD);
    assign rd_d  = (r_d.st == ST_READ);
    assign wr_d  = (r_d.st == ST_WRITE);

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (ld),
        .load_val_i(ld_val),
        .last_o    (last)
    );

    sram_pin_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_d  (sel_d),
        .rd_d   (rd_d),
        .wr_d   (wr_d),
        .a_d    (r_d.a),
        .dat_d  (r_d.wd),
        .sel_n_o(mem_sel_n_o),
        .sel_o  (mem_sel_o),
        .rd_n_o (mem_rd_n_o),
        .wr_n_o (mem_wr_n_o),
        .d_oe_o (mem_d_oe_o),
        .a_o    (mem_a_o),
        .d_o    (mem_d_o)
    );

    assign rdata_o = r_q.rd;
    assign done_o  = r_q.done;
    assign busy_o  = (r_q.st != ST_IDLE);
endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done_o,
    input logic              busy_o,
    input logic [ADDR_W-1:0] mem_a_o,
    input logic [DATA_W-1:0] mem_d_o,
    input logic              mem_d_oe_o,
    input logic              mem_sel_n_o,
    input logic              mem_sel_o,
    input logic              mem_rd_n_o,
    input logic              mem_wr_n_o
);
    // R1
    idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (mem_sel_n_o && !mem_sel_o && mem_rd_n_o && mem_wr_n_o && !mem_d_oe_o));

    // R2
    rd_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_n_o |-> (!mem_sel_n_o && mem_sel_o && mem_wr_n_o));

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6
    drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_d_oe_o |-> (!mem_wr_n_o && !mem_sel_n_o));

    // R7
    addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_sel_n_o && !$past(mem_sel_n_o)) |-> $stable(mem_a_o));

    // R7
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_n_o) |-> (!mem_sel_n_o && !mem_d_oe_o && $stable(mem_d_o)));
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_o     (done_o),
    .busy_o     (busy_o),
    .mem_a_o    (mem_a_o),
    .mem_d_o    (mem_d_o),
    .mem_d_oe_o (mem_d_oe_o),
    .mem_sel_n_o(mem_sel_n_o),
    .mem_sel_o  (mem_sel_o),
    .mem_rd_n_o (mem_rd_n_o),
    .mem_wr_n_o (mem_wr_n_o)
);

// File: tb/sram_async_ctrl_bench.sv
module sram_async_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SPEED      = 70;

    function automatic int cdiv(input int ns);
        int c;
        c = (ns + CLK_PERIOD - 1) / CLK_PERIOD;
        return (c < 1) ? 1 : c;
    endfunction

    // grade 70 values
    localparam int EXP_RD = cdiv(70);
    localparam int EXP_WE = (cdiv(60) > cdiv(70) - 1) ? cdiv(60) : cdiv(70) - 1;
    localparam int EXP_HZ = cdiv(25);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [16:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        done, busy;
    logic [16:0] ma;
    logic [7:0]  mdo, mdi;
    logic        moe, sel_n, sel, rd_n, wr_n;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    sram_async_ctrl #(.CLK_NS(CLK_PERIOD), .SPEED_NS(SPEED)) u_sram_async_ctrl (
        .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .done_o(done), .busy_o(busy),
        .mem_a_o(ma), .mem_d_o(mdo), .mem_d_oe_o(moe), .mem_d_i(mdi),
        .mem_sel_n_o(sel_n), .mem_sel_o(sel), .mem_rd_n_o(rd_n), .mem_wr_n_o(wr_n)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // memory model: late data, late release
    logic [7:0] mem [1024];
    int age = 0;
    int rel = 0;
    logic m_rd, m_drv;
    assign m_rd  = !sel_n && sel && !rd_n && wr_n;
    assign m_drv = m_rd || (rel != 0);
    assign mdi   = m_drv ? ((m_rd && age >= EXP_RD - 1) ? mem[ma[9:0]] : ~mem[ma[9:0]]) : 8'h5A;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) mem[i] <= 8'h00;
            age <= 0;
            rel <= 0;
        end else begin
            if (!sel_n && sel && !wr_n && moe) mem[ma[9:0]] <= mdo;
            age <= m_rd ? age + 1 : 0;
            rel <= m_rd ? EXP_HZ : ((rel != 0) ? rel - 1 : 0);
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // R4: no contention between controller and memory
    always @(negedge clk) begin
        if (rst_n && moe && m_drv) begin
            total++;
            bad++;
            $display("FAIL R4 bus contention act=%0h exp=%0h", 1, 0);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    function automatic logic [16:0] adr(input int i);
        return 17'((i * 2053) & 17'h1FFFF);
    endfunction

    task automatic check_idle(input string tag);
        chk(sel_n && !sel && rd_n && wr_n && !moe && !busy, tag,
            {sel_n, sel, rd_n, wr_n, moe, busy}, 6'b101100);
    endtask

    // called at a negedge; returns at the negedge where done is seen
    task automatic do_write(input logic [16:0] a, input logic [7:0] d, input bit poke);
        req = 1'b1; we = 1'b1; addr = a; wdata = d;
        for (int k = 1; k <= EXP_WE + 2; k++) begin
            @(negedge clk);
            if (k == 1) req = 1'b0;
            if (poke && k == 2) begin req = 1'b1; we = 1'b0; addr = a ^ 17'h155; end
            if (poke && k == 3) req = 1'b0;
            if (k <= EXP_WE) begin
                chk(!wr_n && !sel_n && sel && rd_n, "R5 write enable window", {wr_n, sel_n, sel, rd_n}, 4'b0011);
                chk(moe && mdo == d, "R6 data driven while write low", {moe, mdo}, {1'b1, d});
                chk(ma == a, "R8 address kept during write", ma, a);
            end else if (k == EXP_WE + 1) begin
                chk(wr_n && !sel_n && !moe && ma == a && mdo == d && busy,
                    "R7 hold cycle", {wr_n, sel_n, moe, busy, ma, mdo}, {4'b1001, a, d});
            end else begin
                chk(done && !busy, "R9 write done, busy low", {done, busy}, 2'b10);
                check_idle("R1 idle after write");
            end
        end
    endtask

    task automatic do_read(input logic [16:0] a, input logic [7:0] exp, input bit poke);
        req = 1'b1; we = 1'b0; addr = a;
        for (int k = 1; k <= EXP_RD + EXP_HZ + 1; k++) begin
            @(negedge clk);
            if (k == 1) req = 1'b0;
            if (poke && k == 2) begin req = 1'b1; we = 1'b1; addr = a ^ 17'h155; wdata = 8'hEE; end
            if (poke && k == 3) req = 1'b0;
            if (k <= EXP_RD) begin
                chk(!sel_n && sel && !rd_n && wr_n && !moe, "R2 read window",
                    {sel_n, sel, rd_n, wr_n, moe}, 5'b01010);
                chk(ma == a, "R2 read address steady", ma, a);
            end else if (k == EXP_RD + 1) begin
                chk(done && rdata == exp, "R3 read data with done", {done, rdata}, {1'b1, exp});
                chk(sel_n && !sel && rd_n && busy, "R4 release then turnaround",
                    {sel_n, sel, rd_n, busy}, 4'b1011);
            end else if (k <= EXP_RD + EXP_HZ) begin
                chk(busy && !done && sel_n, "R4 turnaround busy", {busy, done, sel_n}, 3'b101);
            end else begin
                chk(!busy, "R9 read busy length", busy, 0);
                check_idle("R1 idle after read");
            end
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check_idle("R1 reset state");
        chk(!done, "R1 no done in reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 idle after reset");

        for (int i = 0; i < 64; i++) do_write(adr(i), pat(i), i == 5);
        // R8: request raised during a write was dropped
        @(negedge clk);
        check_idle("R8 no access after dropped request");

        do_write(17'h1FFFF, 8'hC3, 1'b0);
        do_read(17'h1FFFF, 8'hC3, 1'b0);
        do_write(17'h00000, 8'h3C, 1'b0);

        for (int i = 1; i < 64; i++) do_read(adr(i), pat(i), i == 9);
        do_read(17'h00000, 8'h3C, 1'b0);
        // R8: write raised during read number 9 must not have reached memory
        do_read(adr(9) ^ 17'h155, 8'h00, 1'b0);
        @(negedge clk);
        check_idle("R8 idle at end");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule